// File: doc/BRIEF.md
# Dual Periodic Down-Counter with Interrupt Aggregation

This block holds two independent down-counting timers behind a small word-wide register bus. Each timer keeps a stored divider value and a control word. A control write selects an action (copy the divider into the counter, halt, or run periodically) and picks which of four externally generated tick enables drives the timer. A running timer counts down on its chosen tick. When it expires, it reloads and posts a sticky flag.

The two flags form a raw interrupt status. Software reads the status, enables the flags it wants through a mask, and clears them by writing ones to an acknowledge location that never holds a value. A single level interrupt is high while any enabled flag is set. A free-running time counter, advanced by its own tick input, can also be read. Clock generation stays outside the block, because every rate arrives as a one-cycle enable.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset both counters read 0 and are halted, raw status reads 0, mask reads 0, the time counter reads 0 and `irq` is low.
- R2: A write to a timer's divider offset (0x00 timer0, 0x10 timer1) only stores the value, and the counter is unchanged. Every accepted control write (0x08 timer0, 0x18 timer1) latches the stored divider as the reload limit.
- R3: Control bits [1:0] are the action. 0 copies the divider into the counter, 1 halts it and the count holds, 2 makes it run. A control write with action 3 is discarded whole. In a cycle with a control write, a tick does not move that counter.
- R4: Control bits [4:2] are the rate code. Codes 4, 5, 6 and 7 select `rate_tick[0]`, `[1]`, `[2]` and `[3]`. Codes 0 to 3 never advance the counter.
- R5: On a selected tick while running, a count above 1 decrements. A count of 1 or 0 reloads the limit and expires the timer. The expiry sets raw status bit 0 (timer0) or bit 1 (timer1) at that same clock edge, and the bit stays set until it is acknowledged.
- R6: Writing the acknowledge offset 0x4C clears each raw status bit written as 1. Reading 0x4C returns 0. If an expiry falls in the same cycle as an acknowledge of its bit, the bit stays set.
- R7: The mask at 0x48 holds bits [1:0] and reads back. Offset 0x54 returns raw AND mask, and `irq` is high exactly when that value is non-zero, starting the cycle after the write or expiry that changed it.
- R8: The time counter at 0x38 increments on each `time_tick` and wraps from all ones to 0. Counts read at 0x04 and 0x14 and raw status at 0x50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per word write |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rate_tick | input | 4 | Four rate enables selectable by either timer |
| time_tick | input | 1 | Advance enable for the time counter |
| irq | output | 1 | Level interrupt, any enabled flag set |

## Verification
Two pairs of events can land in the same cycle. The first is a timer expiry and a software acknowledge of the same flag. The bench drives the acknowledge write and the final expiring tick on one clock edge and expects the flag to survive and the interrupt to stay up. The second is a control write coinciding with a selected tick. The bench drives both on one edge and expects the count to stay where the write left it, not decremented.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

   localparam int unsigned BUS_W   = 32;
   localparam int unsigned ADDR_W  = 8;
   localparam int unsigned N_TMR   = 2;
   localparam int unsigned RATE_W  = 3;

   // per-timer window: base = index * stride
   localparam logic [ADDR_W-1:0] TMR_STRIDE = 8'h10;
   localparam logic [ADDR_W-1:0] OFS_DIV    = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_CNT    = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_CTL    = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_TIME   = 8'h38;
   localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h48;
   localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h4C;
   localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h50;
   localparam logic [ADDR_W-1:0] OFS_MSKD   = 8'h54;

   typedef enum logic [1:0] {
      ACT_LOAD = 2'd0,
      ACT_HALT = 2'd1,
      ACT_RUN  = 2'd2,
      ACT_BAD  = 2'd3
   } tmr_act_e;

   typedef struct packed {
      logic [RATE_W-1:0] rate;
      tmr_act_e          act;
   } tmr_ctl_t;

endpackage

// File: rtl/dtt_counter.sv
module dtt_counter
   import dtt_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned N_RATES   = 4,
   parameter int unsigned RATE_BASE = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               div_we,
   input  logic               ctl_we,
   input  logic [BUS_W-1:0]   wdata,
   input  logic [N_RATES-1:0] rate_tick,
   output logic [CNT_W-1:0]   count,
   output logic               running,
   output logic               expire
);

   localparam int unsigned CTL_W = $bits(tmr_ctl_t);

   if (CNT_W > BUS_W || CNT_W < 2) begin : g_bad_cnt_w
      $error("dtt_counter: CNT_W out of range");
   end
   if (RATE_BASE + N_RATES > (1 << RATE_W)) begin : g_bad_rates
      $error("dtt_counter: rate codes exceed field");
   end

   logic [CNT_W-1:0]  div_q, lim_q, cnt_q;
   logic [RATE_W-1:0] rate_q;
   logic              run_q;
   tmr_ctl_t          ctl_in;
   logic              ctl_take, sel_tick, at_end;

   assign ctl_in   = tmr_ctl_t'(wdata[CTL_W-1:0]);
   assign ctl_take = ctl_we && (ctl_in.act != ACT_BAD);

   always_comb begin
      sel_tick = 1'b0;
      for (int k = 0; k < int'(N_RATES); k++) begin
         if (rate_q == RATE_W'(RATE_BASE + k)) sel_tick = rate_tick[k];
      end
   end

   assign at_end = (cnt_q <= CNT_W'(1));
   assign expire = !ctl_take && run_q && sel_tick && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         lim_q  <= '0;
         cnt_q  <= '0;
         rate_q <= '0;
         run_q  <= 1'b0;
      end else begin
         if (div_we) div_q <= wdata[CNT_W-1:0];
         if (ctl_take) begin
            lim_q  <= div_q;
            rate_q <= ctl_in.rate;
            unique case (ctl_in.act)
               ACT_LOAD: cnt_q <= div_q;
               ACT_HALT: run_q <= 1'b0;
               ACT_RUN:  run_q <= 1'b1;
               default:  ;
            endcase
         end else if (run_q && sel_tick) begin
            cnt_q <= at_end ? lim_q : cnt_q - CNT_W'(1);
         end
      end
   end

   assign count   = cnt_q;
   assign running = run_q;

endmodule

// File: rtl/dtt_irq.sv
module dtt_irq #(
   parameter int unsigned N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] hit,
   input  logic             mask_we,
   input  logic             ack_we,
   input  logic [N_SRC-1:0] wbits,
   output logic [N_SRC-1:0] raw,
   output logic [N_SRC-1:0] mask,
   output logic             irq
);

   if (N_SRC < 1) begin : g_bad_src
      $error("dtt_irq: N_SRC must be positive");
   end

   logic [N_SRC-1:0] raw_q, mask_q;

   for (genvar b = 0; b < int'(N_SRC); b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 raw_q[b] <= 1'b0;
         else if (hit[b])            raw_q[b] <= 1'b1;
         else if (ack_we && wbits[b]) raw_q[b] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= wbits;
   end

   assign raw  = raw_q;
   assign mask = mask_q;
   assign irq  = |(raw_q & mask_q);

endmodule

// File: rtl/dtt_freerun.sv
module dtt_freerun #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] value
);

   if (W < 1 || W > 32) begin : g_bad_w
      $error("dtt_freerun: W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= '0;
      else if (step) value <= value + W'(1);
   end

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
   import dtt_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned TIME_W  = 32,
   parameter int unsigned N_RATES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [7:0]         bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [N_RATES-1:0] rate_tick,
   input  logic               time_tick,
   output logic               irq
);

   if (N_RATES != 4) begin : g_bad_rates
      $error("dual_tick_timer: rate field decodes four enables");
   end

   logic [CNT_W-1:0]  cnt_w [N_TMR];
   logic [N_TMR-1:0]  run_w, hit_w, raw_w, mask_w;
   logic [TIME_W-1:0] time_w;

   for (genvar g = 0; g < int'(N_TMR); g++) begin : g_tmr
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(g * TMR_STRIDE);
      dtt_counter #(
         .CNT_W     (CNT_W),
         .N_RATES   (N_RATES),
         .RATE_BASE (4)
      ) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .div_we    (bus_wr && bus_addr == BASE + OFS_DIV),
         .ctl_we    (bus_wr && bus_addr == BASE + OFS_CTL),
         .wdata     (bus_wdata),
         .rate_tick (rate_tick),
         .count     (cnt_w[g]),
         .running   (run_w[g]),
         .expire    (hit_w[g])
      );
   end

   dtt_irq #(.N_SRC(N_TMR)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit_w),
      .mask_we (bus_wr && bus_addr == OFS_MASK),
      .ack_we  (bus_wr && bus_addr == OFS_ACK),
      .wbits   (bus_wdata[N_TMR-1:0]),
      .raw     (raw_w),
      .mask    (mask_w),
      .irq     (irq)
   );

   dtt_freerun #(.W(TIME_W)) u_time (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (time_tick),
      .value (time_w)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_CNT:              bus_rdata = 32'(cnt_w[0]);
         TMR_STRIDE + OFS_CNT: bus_rdata = 32'(cnt_w[1]);
         OFS_TIME:             bus_rdata = 32'(time_w);
         OFS_MASK:             bus_rdata = 32'(mask_w);
         OFS_RAW:              bus_rdata = 32'(raw_w);
         OFS_MSKD:             bus_rdata = 32'(raw_w & mask_w);
         default:              bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/dtt_chk.sv
module dtt_chk #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned TIME_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [7:0]        bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              time_tick,
   input logic              irq,
   input logic [1:0]        hit,
   input logic [1:0]        raw,
   input logic [1:0]        mask,
   input logic              run0,
   input logic [CNT_W-1:0]  cnt0,
   input logic [TIME_W-1:0] time_val
);

   a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !irq)
      else $error("R1 irq high out of reset");

   a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run0 && !(bus_wr && bus_addr == 8'h08)) |=> $stable(cnt0))
      else $error("R3 halted count moved");

   a_r5_hit0_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      hit[0] |=> raw[0])
      else $error("R5 expiry of timer0 not posted");

   a_r5_hit1_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      hit[1] |=> raw[1])
      else $error("R5 expiry of timer1 not posted");

   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h4C && bus_wdata[0] && !hit[0]) |=> !raw[0])
      else $error("R6 acknowledge left flag set");

   a_r7_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == 2'b00) |-> !irq)
      else $error("R7 irq with empty mask");

   a_r8_time_step: assert property (@(posedge clk) disable iff (!rst_n)
      time_tick |=> time_val == TIME_W'($past(time_val) + TIME_W'(1)))
      else $error("R8 time counter step wrong");

endmodule

bind dual_tick_timer dtt_chk #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .time_tick (time_tick),
   .irq       (irq),
   .hit       (hit_w),
   .raw       (raw_w),
   .mask      (mask_w),
   .run0      (run_w[0]),
   .cnt0      (cnt_w[0]),
   .time_val  (time_w)
);

// File: tb/dual_tick_timer_tb.sv
module dual_tick_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  rate_tick = '0;
   logic        time_tick = 1'b0;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   typedef struct {
      bit          pin;
      logic [7:0]  addr;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   event     smp;

   always #10 clk = ~clk;

   dual_tick_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rate_tick (rate_tick),
      .time_tick (time_tick),
      .irq       (irq)
   );

   // monitor: pops the expected item and compares the live output
   always @(smp) begin
      sb_item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.pin ? {31'b0, irq} : bus_rdata;
      n_cmp++;
      if (act !== it.exp) begin
         n_bad++;
         $display("FAIL %s: %s%h actual=%h expected=%h", it.tag,
                  it.pin ? "irq " : "addr ", it.addr, act, it.exp);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] tk = 4'b0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; rate_tick = tk;
      @(negedge clk);
      bus_wr = 1'b0; rate_tick = '0;
   endtask

   task automatic tick(input logic [3:0] tk, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); rate_tick = tk;
         @(negedge clk); rate_tick = '0;
      end
   endtask

   task automatic tstep(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); time_tick = 1'b1;
         @(negedge clk); time_tick = 1'b0;
      end
   endtask

   task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      sb_item_t it;
      @(negedge clk);
      bus_addr = a;
      it.pin = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      #2 -> smp;
      #1;
   endtask

   task automatic exp_irq(input logic e, input string tag);
      sb_item_t it;
      @(negedge clk);
      it.pin = 1'b1; it.addr = 8'h00; it.exp = {31'b0, e}; it.tag = tag;
      sb_q.push_back(it);
      #2 -> smp;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      exp_rd(8'h04, 32'd0, "R1 count0");
      exp_rd(8'h14, 32'd0, "R1 count1");
      exp_rd(8'h50, 32'd0, "R1 raw");
      exp_rd(8'h48, 32'd0, "R1 mask");
      exp_rd(8'h38, 32'd0, "R1 time");
      exp_irq(1'b0, "R1 irq");

      // R2 divider store only, then load via control action 0, rate code 4
      wr(8'h00, 32'd5);
      exp_rd(8'h04, 32'd0, "R2 divider write leaves count");
      wr(8'h08, 32'h10);
      exp_rd(8'h04, 32'd5, "R2 load copies divider");

      // R3 run, R4 rate select
      wr(8'h08, 32'h12);
      tick(4'b0001, 3);
      exp_rd(8'h04, 32'd2, "R3 run decrements");
      tick(4'b1110, 2);
      exp_rd(8'h04, 32'd2, "R4 unselected rates ignored");
      wr(8'h08, 32'h11);
      tick(4'b0001, 2);
      exp_rd(8'h04, 32'd2, "R3 halt holds count");

      // R3 control write and tick in one cycle: write wins
      wr(8'h08, 32'h12, 4'b0001);
      exp_rd(8'h04, 32'd2, "R3 tick during control write ignored");

      // R5 expiry and reload
      tick(4'b0001, 2);
      exp_rd(8'h04, 32'd5, "R5 reload at expiry");
      exp_rd(8'h50, 32'd1, "R5 raw bit0 set");
      exp_rd(8'h54, 32'd0, "R7 masked with empty mask");
      exp_irq(1'b0, "R7 irq masked off");
      wr(8'h48, 32'd1);
      exp_rd(8'h48, 32'd1, "R7 mask readback");
      exp_rd(8'h54, 32'd1, "R7 masked status");
      exp_irq(1'b1, "R7 irq raised");

      // R6 acknowledge
      wr(8'h4C, 32'd1);
      exp_rd(8'h50, 32'd0, "R6 ack clears bit0");
      exp_rd(8'h4C, 32'd0, "R6 ack reads zero");
      exp_irq(1'b0, "R6 irq dropped");

      // R3 action 3 discarded (would set rate 0 otherwise)
      wr(8'h08, 32'h03);
      tick(4'b0001, 1);
      exp_rd(8'h04, 32'd4, "R3 action 3 discarded");

      // timer1 on rate code 7
      wr(8'h10, 32'd2);
      wr(8'h18, 32'h1C);
      exp_rd(8'h14, 32'd2, "R2 timer1 load");
      wr(8'h18, 32'h1E);
      tick(4'b1000, 2);
      exp_rd(8'h14, 32'd2, "R5 timer1 reload");
      exp_rd(8'h50, 32'd2, "R5 raw bit1 set");
      exp_irq(1'b0, "R7 bit1 not enabled");
      wr(8'h48, 32'd3);
      exp_rd(8'h54, 32'd2, "R7 masked bit1");
      exp_irq(1'b1, "R7 irq from bit1");

      // R4 rate code 1 never advances
      wr(8'h08, 32'h06);
      tick(4'b1111, 3);
      exp_rd(8'h04, 32'd4, "R4 rate code 1 frozen");

      // R6 ack and expiry in the same cycle
      wr(8'h4C, 32'd3);
      exp_rd(8'h50, 32'd0, "R6 ack clears both");
      wr(8'h00, 32'd2);
      wr(8'h08, 32'h10);
      wr(8'h08, 32'h12);
      tick(4'b0001, 1);
      exp_rd(8'h04, 32'd1, "R5 count at one");
      wr(8'h4C, 32'd1, 4'b0001);
      exp_rd(8'h50, 32'd1, "R6 expiry beats ack");
      exp_rd(8'h04, 32'd2, "R5 reload after coincident ack");
      exp_irq(1'b1, "R6 irq held by new expiry");

      // R8 time counter
      tstep(7);
      exp_rd(8'h38, 32'd7, "R8 time counts ticks");

      @(negedge clk);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule